// File: doc/BRIEF.md
# Per-Channel Interrupt Mask Controller

This block collects completion events from eight transmit and eight receive DMA channel engines, plus a two-bit DMA error group, and turns them into one interrupt line. Each group keeps a sticky raw status word and an enable mask. The mask changes only through a write-one-to-set register and a write-one-to-clear register. The raw and masked views can be read side by side.

Software reaches the block over a plain 32-bit register port: one write strobe, one address and write data, and combinational read data. An end-of-interrupt register acknowledges raw bits. A self-clearing soft-reset register wipes all masks and status. It reports completion by reading back zero a fixed number of cycles after it was started.

Top module: `chan_irq_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, every raw status and mask reads 0, the soft-reset register at 0x1C reads 0, and `irq_out` is 0.
- R2: An event input that is high in a cycle sets the raw bit whose index is its channel number. Raw status reads at 0x80 (transmit), 0xA0 (receive) and 0xB0 (DMA). In the DMA group, bit 1 is the host-error event. An event arriving in the same cycle as its acknowledge leaves the bit set.
- R3: Writing to a mask-set register (0x88, 0xA8, 0xB8) enables each channel whose data bit is 1. Channels whose data bit is 0 keep their mask.
- R4: Writing to a mask-clear register (0x8C, 0xAC, 0xBC) disables each channel whose data bit is 1. Writing 0xFFFFFFFF disables the whole group.
- R5: Reading either mask register of a group returns that group's current mask.
- R6: The masked status at 0x84, 0xA4 and 0xB4 reads raw AND mask. Writes to the raw and masked addresses change nothing.
- R7: `irq_out` is high exactly when some bit of any group is both raw-set and enabled.
- R8: A raw bit stays set until a write to 0x94 carries a 1 in that channel's acknowledge position. Transmit channels map to data bits 7:0, receive channels to bits 15:8, and the DMA group to bits 17:16.
- R9: Writing data with bit 0 = 1 to 0x1C starts a soft reset. 0x1C then reads 1 for 4 cycles after the write edge and 0 afterwards. Writing bit 0 = 0 starts nothing.
- R10: From the soft-reset write edge until the register reads 0 again, all raw bits and masks are held at 0. Events and mask writes in that window are lost.
- R11: Any address not named above reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| tx_evt | input | 8 | Transmit channel completion events |
| rx_evt | input | 8 | Receive channel completion events |
| dma_evt | input | 2 | DMA error events (bit 1 host error) |
| irq_out | output | 1 | Combined interrupt |

## Verification
The hardest cases to reach from the ports involve collisions in a single cycle: an event arriving on the exact edge that its end-of-interrupt write clears it, and events or mask writes landing inside the short soft-reset window. Directed sequences place the event pulse in the same cycle as the acknowledge write. They also drive events from the falling edge in the middle of the reset window while polling the soft-reset register cycle by cycle. A long phase of random writes, events and soft resets is then compared on every clock against a behavioural model, on both the read data for the current address and the interrupt line.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int NGRP   = 3;

    localparam logic [ADDR_W-1:0] OFS_SRST = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_EOI  = 8'h94;

    typedef enum logic [1:0] {
        VIEW_RAW  = 2'd0,
        VIEW_PEND = 2'd1,
        VIEW_SET  = 2'd2,
        VIEW_CLR  = 2'd3
    } view_e;

    typedef struct packed {
        logic  hit;
        view_e view;
    } dec_t;

    // Four word registers per group, aligned on a 16-byte block.
    function automatic dec_t grp_decode(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] base);
        dec_t d;
        d.hit  = (a[ADDR_W-1:4] == base[ADDR_W-1:4]) && (a[1:0] == 2'b00);
        d.view = view_e'(a[3:2]);
        return d;
    endfunction

endpackage

// File: rtl/irqc_group.sv
module irqc_group #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wipe,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] ack,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wd,
    output logic [W-1:0] raw_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] pend_o
);

    logic [W-1:0] raw_q, mask_q;

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~ack) | evt;
            if (set_we)
                mask_q <= mask_q | wd;
            else if (clr_we)
                mask_q <= mask_q & ~wd;
        end
    end

    assign raw_o  = raw_q;
    assign mask_o = mask_q;
    assign pend_o = raw_q & mask_q;

    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        (set_we && !wipe) |=> ((mask_o & $past(wd)) == $past(wd)));

    // R4
    mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !wipe) |=> ((mask_o & $past(wd)) == '0));

    // R2
    evt_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!wipe) |=> ((raw_o & $past(evt)) == $past(evt)));

    // R8
    raw_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!wipe) |=> (($past(raw_o) & ~$past(ack) & ~raw_o) == '0));

endmodule

// File: rtl/irqc_srst.sv
module irqc_srst #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CW'(CYC);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    // R9
    srst_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R9
    srst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !busy);

endmodule

// File: rtl/chan_irq_ctrl.sv
module chan_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int N_CH    = 8,
    parameter int DMA_W   = 2,
    parameter int RST_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_CH-1:0]   tx_evt,
    input  logic [N_CH-1:0]   rx_evt,
    input  logic [DMA_W-1:0]  dma_evt,
    output logic              irq_out
);

    localparam int GW      [NGRP] = '{N_CH, N_CH, DMA_W};
    localparam int ACK_LSB [NGRP] = '{0, N_CH, 2 * N_CH};
    localparam logic [ADDR_W-1:0] GBASE [NGRP] = '{8'h80, 8'hA0, 8'hB0};

    logic [DATA_W-1:0] evt_g  [NGRP];
    logic [DATA_W-1:0] raw_g  [NGRP];
    logic [DATA_W-1:0] mask_g [NGRP];
    logic [DATA_W-1:0] pend_g [NGRP];
    dec_t              dec_g  [NGRP];
    logic [NGRP-1:0]   any_pend;

    logic srst_start, srst_busy, wipe, eoi_we;

    assign evt_g[0]   = DATA_W'(tx_evt);
    assign evt_g[1]   = DATA_W'(rx_evt);
    assign evt_g[2]   = DATA_W'(dma_evt);

    assign srst_start = reg_wr && (reg_addr == OFS_SRST) && reg_wdata[0];
    assign eoi_we     = reg_wr && (reg_addr == OFS_EOI);
    assign wipe       = srst_start || srst_busy;

    irqc_srst #(.CYC(RST_CYC)) u_srst (
        .clk   (clk),
        .rst   (rst),
        .start (srst_start),
        .busy  (srst_busy)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int W = GW[g];
        logic [W-1:0] raw_w, mask_w, pend_w, ack_w;

        assign dec_g[g] = grp_decode(reg_addr, GBASE[g]);
        assign ack_w    = eoi_we ? reg_wdata[ACK_LSB[g] +: W] : '0;

        irqc_group #(.W(W)) u_grp (
            .clk    (clk),
            .rst    (rst),
            .wipe   (wipe),
            .evt    (evt_g[g][W-1:0]),
            .ack    (ack_w),
            .set_we (reg_wr && dec_g[g].hit && dec_g[g].view == VIEW_SET),
            .clr_we (reg_wr && dec_g[g].hit && dec_g[g].view == VIEW_CLR),
            .wd     (reg_wdata[W-1:0]),
            .raw_o  (raw_w),
            .mask_o (mask_w),
            .pend_o (pend_w)
        );

        assign raw_g[g]    = DATA_W'(raw_w);
        assign mask_g[g]   = DATA_W'(mask_w);
        assign pend_g[g]   = DATA_W'(pend_w);
        assign any_pend[g] = |pend_w;
    end

    assign irq_out = |any_pend;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_SRST)
            reg_rdata[0] = srst_busy;
        for (int g = 0; g < NGRP; g++) begin
            if (dec_g[g].hit) begin
                unique case (dec_g[g].view)
                    VIEW_RAW:  reg_rdata = raw_g[g];
                    VIEW_PEND: reg_rdata = pend_g[g];
                    VIEW_SET,
                    VIEW_CLR:  reg_rdata = mask_g[g];
                endcase
            end
        end
    end

    // R10
    srst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        srst_busy |-> ((raw_g[0] | raw_g[1] | raw_g[2] |
                        mask_g[0] | mask_g[1] | mask_g[2]) == '0));

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        srst_busy |-> !irq_out);

endmodule

// File: tb/test_chan_irq_ctrl.sv
module test_chan_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  tx_evt = '0;
    logic [7:0]  rx_evt = '0;
    logic [1:0]  dma_evt = '0;
    logic        irq_out;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit cmp_en = 1'b0;

    // reference model state
    logic [31:0] m_raw [3];
    logic [31:0] m_msk [3];
    int          m_cnt;

    chan_irq_ctrl i_chan_irq_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_evt(tx_evt),
        .rx_evt(rx_evt), .dma_evt(dma_evt), .irq_out(irq_out)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] gwid(int g);
        return (g == 2) ? 32'h3 : 32'hFF;
    endfunction

    function automatic int grp_of(logic [7:0] a);
        case (a[7:4])
            4'h8:    return 0;
            4'hA:    return 1;
            4'hB:    return 2;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] model_read(logic [7:0] a);
        int g = grp_of(a);
        if (a == 8'h1C) return {31'b0, m_cnt > 0};
        if (g < 0 || a[1:0] != 2'b00) return 32'h0;
        case (a[3:2])
            2'd0:    return m_raw[g];
            2'd1:    return m_raw[g] & m_msk[g];
            default: return m_msk[g];
        endcase
    endfunction

    function automatic string tag_of(logic [7:0] a);
        if (a == 8'h1C) return "R9";
        if (grp_of(a) < 0 || a[1:0] != 2'b00) return "R11";
        case (a[3:2])
            2'd0:    return "R2";
            2'd1:    return "R6";
            default: return "R5";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < 3; g++) begin m_raw[g] = '0; m_msk[g] = '0; end
            m_cnt = 0;
        end else begin
            bit start, wipe;
            logic [31:0] ack [3];
            logic [31:0] ev [3];
            start = reg_wr && reg_addr == 8'h1C && reg_wdata[0];
            wipe  = start || (m_cnt > 0);
            if (start) m_cnt = 4; else if (m_cnt > 0) m_cnt--;
            ev[0] = {24'b0, tx_evt}; ev[1] = {24'b0, rx_evt}; ev[2] = {30'b0, dma_evt};
            ack[0] = '0; ack[1] = '0; ack[2] = '0;
            if (reg_wr && reg_addr == 8'h94) begin
                ack[0] = {24'b0, reg_wdata[7:0]};
                ack[1] = {24'b0, reg_wdata[15:8]};
                ack[2] = {30'b0, reg_wdata[17:16]};
            end
            for (int g = 0; g < 3; g++) begin
                if (wipe) begin
                    m_raw[g] = '0; m_msk[g] = '0;
                end else begin
                    m_raw[g] = (m_raw[g] & ~ack[g]) | ev[g];
                    if (reg_wr && grp_of(reg_addr) == g && reg_addr[1:0] == 2'b00) begin
                        if (reg_addr[3:2] == 2'd2) m_msk[g] = m_msk[g] | (reg_wdata & gwid(g));
                        if (reg_addr[3:2] == 2'd3) m_msk[g] = m_msk[g] & ~reg_wdata;
                    end
                end
            end
        end
    end

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (cmp_en) begin
            logic [31:0] e;
            bit ei;
            e  = model_read(reg_addr);
            ei = |((m_raw[0] & m_msk[0]) | (m_raw[1] & m_msk[1]) | (m_raw[2] & m_msk[2]));
            tests++;
            if (reg_rdata !== e) begin
                fails++;
                $display("FAIL %s model addr=%h actual=%h expected=%h", tag_of(reg_addr), reg_addr, reg_rdata, e);
            end
            tests++;
            if (irq_out !== ei) begin
                fails++;
                $display("FAIL R7 model irq actual=%b expected=%b", irq_out, ei);
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        @(posedge clk); #2;
        reg_addr = a;
        @(negedge clk);
        check(tag, reg_rdata, exp);
    endtask

    task automatic pulse(logic [7:0] t, logic [7:0] r, logic [1:0] d);
        @(posedge clk); #2;
        tx_evt = t; rx_evt = r; dma_evt = d;
        @(posedge clk); #2;
        tx_evt = '0; rx_evt = '0; dma_evt = '0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                $display("FAIL watchdog expired");
                summary();
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        cmp_en = 1'b1;

        // R1 reset state
        rd(8'h80, 32'h0, "R1 tx raw");
        rd(8'hB8, 32'h0, "R1 dma mask");
        rd(8'h1C, 32'h0, "R1 srst");
        check("R1 irq", {31'b0, irq_out}, 32'h0);

        // R2 capture, R3/R5/R6/R7
        pulse(8'h05, 8'h00, 2'b00);
        rd(8'h80, 32'h05, "R2 tx raw");
        check("R7 irq masked off", {31'b0, irq_out}, 32'h0);
        wr(8'h88, 32'h04);
        rd(8'h8C, 32'h04, "R5 mask via clear reg");
        rd(8'h84, 32'h04, "R6 masked view");
        check("R7 irq on", {31'b0, irq_out}, 32'h1);
        wr(8'h88, 32'h01);
        rd(8'h88, 32'h05, "R3 zero bits keep mask");
        wr(8'h8C, 32'h04);
        rd(8'h88, 32'h01, "R4 clear one bit");
        wr(8'h84, 32'hFFFF_FFFF);
        wr(8'h80, 32'h0);
        rd(8'h80, 32'h05, "R6 raw/masked writes ignored");

        // DMA host error and R8 acknowledge
        pulse(8'h00, 8'h00, 2'b10);
        wr(8'hB8, 32'h2);
        rd(8'hB4, 32'h2, "R2 host error bit1");
        wr(8'h94, 32'h0002_0000);
        rd(8'hB0, 32'h0, "R8 dma ack");
        rd(8'h80, 32'h05, "R8 tx untouched");

        // R2 event in same cycle as its ack
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_addr = 8'h94; reg_wdata = 32'h1; tx_evt = 8'h01;
        @(posedge clk); #2;
        reg_wr = 1'b0; tx_evt = '0;
        rd(8'h80, 32'h05, "R2 event beats ack");
        wr(8'h94, 32'h05);
        rd(8'h80, 32'h00, "R8 tx ack");

        // R4 clear-all
        pulse(8'h00, 8'h80, 2'b00);
        wr(8'hA8, 32'hFF);
        rd(8'hA4, 32'h80, "R6 rx masked");
        wr(8'hAC, 32'hFFFF_FFFF);
        rd(8'hA8, 32'h00, "R4 clear all");
        check("R7 irq off", {31'b0, irq_out}, 32'h0);

        // R9 write of zero starts nothing
        wr(8'h88, 32'hFF);
        wr(8'h1C, 32'h0);
        rd(8'h1C, 32'h0, "R9 zero write");
        rd(8'h88, 32'hFF, "R9 masks kept");

        // R9/R10 soft reset window
        pulse(8'h03, 8'h00, 2'b00);
        wr(8'h1C, 32'h1);
        reg_addr = 8'h1C;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check($sformatf("R9 busy k=%0d", k), reg_rdata, (k < 4) ? 32'h1 : 32'h0);
            if (k == 1) tx_evt = 8'hFF;
            if (k == 2) tx_evt = 8'h00;
        end
        rd(8'h80, 32'h0, "R10 raw cleared, events lost");
        rd(8'h88, 32'h0, "R10 mask cleared");

        // R11 unmapped
        rd(8'h40, 32'h0, "R11 unmapped");
        rd(8'h94, 32'h0, "R11 eoi reads zero");

        // random phase, checked by the model
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] addrs [14];
            addrs = '{8'h80, 8'h84, 8'h88, 8'h8C, 8'hA0, 8'hA4, 8'hA8, 8'hAC,
                      8'hB0, 8'hB4, 8'hB8, 8'hBC, 8'h94, 8'h1C};
            @(posedge clk); #2;
            reg_addr  = ($urandom % 16 == 0) ? 8'h40 : addrs[$urandom % 14];
            reg_wdata = $urandom;
            reg_wr    = ($urandom % 4 == 0) && !(reg_addr == 8'h1C && ($urandom % 8 != 0));
            tx_evt    = ($urandom % 3 == 0) ? 8'($urandom) : 8'h0;
            rx_evt    = ($urandom % 3 == 0) ? 8'($urandom) : 8'h0;
            dma_evt   = ($urandom % 5 == 0) ? 2'($urandom) : 2'h0;
        end
        @(posedge clk); #2;
        reg_wr = 1'b0; tx_evt = '0; rx_evt = '0; dma_evt = '0;
        repeat (2) @(posedge clk);
        summary();
    end

endmodule